// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block produces the opening part of a LIN frame on a single-wire transmit line. It is paced by a one-cycle tick that an external baud generator raises once per bit time. When a start request arrives while the block is idle, the block arms. On the next tick it pulls the line dominant (logic 0) for a break of 13 to 16 bit times, chosen by a 2-bit code. It then releases the line for a one-bit recessive delimiter and sends the byte held in its transmit register. That byte is normally 0x55, the sync field.

The byte can be written before the request or while the break is running. It waits in a one-entry holding register, and the empty flag stays low until the start bit of that byte goes out. Software can therefore queue the sync byte right after it issues the request, and no empty event occurs between the break and the sync field. If nothing is queued when the delimiter ends, the frame ends there. The line idles recessive (logic 1).

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_out` is 1, `busy` is 0 and `data_empty` is 1.
- R2: A `brk_start` pulse accepted while `busy` is 0 raises `busy` on the next clock. `tx_out` goes to 0 at the first `bit_tick` after the request.
- R3: The break holds `tx_out` at 0 for exactly 13 + `brk_len` bit ticks, so codes 0, 1, 2 and 3 give 13, 14, 15 and 16 bit times. The code is captured when the request is accepted.
- R4: The break is followed by exactly one bit time of `tx_out` = 1 (the delimiter).
- R5: If a byte is queued when the delimiter ends, it is sent next as one 0 start bit, 8 data bits starting from bit 0, no parity, and one 1 stop bit. One bit is sent per tick. The byte 0x55 gives alternating 0 and 1 bits, starting with 1 right after the start bit.
- R6: A write with `wr_en` while `data_empty` is 1 clears `data_empty` on the next clock. `data_empty` stays 0 through the break and the delimiter. It returns to 1 in the same clock that the start bit of that byte appears on `tx_out`.
- R7: If no byte is queued when the delimiter ends, the frame ends: `busy` drops and `tx_out` stays 1.
- R8: A `brk_start` pulse while `busy` is 1 is ignored. The current frame's waveform and length are unchanged.
- R9: A write while `data_empty` is 0 is ignored. The byte already held is the one that gets transmitted.
- R10: `busy` stays 1 until the stop bit of the queued byte has lasted a full bit time, then drops at the following tick.
- R11: `tx_out` changes only in the clock that follows a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time from the baud generator |
| brk_start | input | 1 | Request to start a header with a break |
| brk_len | input | 2 | Break-length code, length = 13 + code bit times |
| wr_en | input | 1 | Write strobe for the transmit-data register |
| wr_data | input | 8 | Byte to queue (normally 0x55) |
| tx_out | output | 1 | Serial line, 0 dominant, 1 recessive |
| data_empty | output | 1 | Transmit-data register holds no byte |
| busy | output | 1 | A header is armed or being sent |

## Verification
The bench sweeps all four break codes against several bytes and checks the line at every bit. An off-by-one in the break counter shows up as a break one bit long or short. A byte released too early would put its start bit where the delimiter belongs, and the empty flag would rise during the break. Other cases cover a byte queued before the request, a frame with no byte, a second write into a full register, and a request during a frame. A design that restarted on that late request would drive a new break over the data bits. A design that accepted the second write would send the wrong byte.

// File: rtl/lin_hdr_pkg.sv
// Shared types for the LIN header transmitter.
package lin_hdr_pkg;
    // Sequencer phases of one header.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_BREAK = 3'd2,
        ST_DELIM = 3'd3,
        ST_FRAME = 3'd4
    } hdr_state_t;
endpackage

// File: rtl/lin_hdr_hold.sv
// One-entry transmit holding register.
// Assumes: a write is taken only while empty; the sequencer pulses take
// exactly when the byte moves into the shifter.
module lin_hdr_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Capture a byte when empty, and release it when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/lin_hdr_shift.sv
// Frame shifter: start bit, data LSB first, stop bit.
// Bit 0 of the register is the line value outside the break. The register
// refills with ones, so the line is recessive when nothing is shifting.
module lin_hdr_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              line_bit
);
    localparam int FRAME_BITS = DATA_W + 2;

    logic [FRAME_BITS-1:0] sr;

    // Load a framed byte or move one bit toward the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '1;
        end else if (load) begin
            sr <= {1'b1, load_data, 1'b0};
        end else if (shift_en) begin
            sr <= {1'b1, sr[FRAME_BITS-1:1]};
        end
    end

    assign line_bit = sr[0];
endmodule

// File: rtl/lin_hdr_seq.sv
// Header sequencer: arm, break, delimiter, then the queued frame.
// Assumes bit_tick is a single-cycle pulse. All phase changes after arming
// happen on a tick.
module lin_hdr_seq
    import lin_hdr_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CODE_W  = 2,
    parameter int BRK_MIN = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              brk_start,
    input  logic [CODE_W-1:0] brk_len,
    input  logic              hold_full,
    output logic              take,
    output logic              shift_en,
    output logic              in_break,
    output logic              busy
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int BRK_MAX    = BRK_MIN + (1 << CODE_W) - 1;
    localparam int CNT_MAX    = (BRK_MAX > FRAME_BITS) ? BRK_MAX : FRAME_BITS;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    hdr_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] brk_last;

    assign take     = (state == ST_DELIM) && bit_tick && hold_full;
    assign shift_en = (state == ST_FRAME) && bit_tick;
    assign in_break = (state == ST_BREAK);
    assign busy     = (state != ST_IDLE);

    // Step through the header phases and count bit times within a phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            brk_last <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (brk_start) begin
                        state    <= ST_ARMED;
                        brk_last <= CNT_W'(BRK_MIN - 1) + CNT_W'(brk_len);
                    end
                end
                ST_ARMED: begin
                    if (bit_tick) begin
                        state <= ST_BREAK;
                        cnt   <= '0;
                    end
                end
                ST_BREAK: begin
                    if (bit_tick) begin
                        if (cnt == brk_last) begin
                            state <= ST_DELIM;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DELIM: begin
                    if (bit_tick) begin
                        cnt   <= '0;
                        state <= hold_full ? ST_FRAME : ST_IDLE;
                    end
                end
                ST_FRAME: begin
                    if (bit_tick) begin
                        if (cnt == CNT_W'(FRAME_BITS - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lin_hdr_tx.sv
// LIN master header transmitter top.
// Combines the sequencer, the holding register and the frame shifter.
// The line is forced dominant during the break. Otherwise it follows the
// shifter, which idles recessive.
module lin_hdr_tx #(
    parameter int DATA_W  = 8,
    parameter int CODE_W  = 2,
    parameter int BRK_MIN = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              brk_start,
    input  logic [CODE_W-1:0] brk_len,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_out,
    output logic              data_empty,
    output logic              busy
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              shift_en;
    logic              in_break;
    logic              line_bit;

    lin_hdr_seq #(.DATA_W(DATA_W), .CODE_W(CODE_W), .BRK_MIN(BRK_MIN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .brk_start(brk_start),
        .brk_len  (brk_len),
        .hold_full(hold_full),
        .take     (take),
        .shift_en (shift_en),
        .in_break (in_break),
        .busy     (busy)
    );

    lin_hdr_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .take   (take),
        .full   (hold_full),
        .data   (hold_data)
    );

    lin_hdr_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .shift_en (shift_en),
        .load_data(hold_data),
        .line_bit (line_bit)
    );

    assign tx_out     = in_break ? 1'b0 : line_bit;
    assign data_empty = ~hold_full;
endmodule

// File: rtl/lin_hdr_tx_chk.sv
// Port-level checker for the LIN header transmitter, bound to the top.
module lin_hdr_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic brk_start,
    input logic wr_en,
    input logic tx_out,
    input logic data_empty,
    input logic busy
);
    // R1: with no frame in progress the line is recessive.
    p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_out);

    // R2: busy only rises after a request.
    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(brk_start));

    // R6: empty only falls after a write.
    p_empty_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_empty) |-> $past(wr_en));

    // R6: empty rises together with the start bit on the line.
    p_empty_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_empty) |-> (!tx_out && busy));

    // R10: a frame ends on a recessive line.
    p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> tx_out);

    // R11: the line moves only after a tick.
    p_tick_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(tx_out));
endmodule

bind lin_hdr_tx lin_hdr_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .brk_start (brk_start),
    .wr_en     (wr_en),
    .tx_out    (tx_out),
    .data_empty(data_empty),
    .busy      (busy)
);

// File: tb/lin_hdr_tx_tb_top.sv
// Sweep bench for the LIN header transmitter.
module lin_hdr_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       brk_start = 1'b0;
    logic [1:0] brk_len = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_out;
    logic       data_empty;
    logic       busy;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    event ev_bit;

    always #5 clk = ~clk;

    lin_hdr_tx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .brk_start (brk_start),
        .brk_len   (brk_len),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_out    (tx_out),
        .data_empty(data_empty),
        .busy      (busy)
    );

    // Bit ticks every four clocks; ev_bit fires at the negedge after a tick edge.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            -> ev_bit;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One header. put: queue a byte; early: before the request;
    // dbl: second write while full; late: request during the frame.
    task automatic run_frame(input int code, input bit put, input bit early,
                             input logic [7:0] b, input bit dbl, input bit late);
        int   len;
        int   last;
        logic etx;
        logic ebusy;
        logic eempty;
        len = 13 + code;
        @(ev_bit);
        if (put && early) begin
            wr_en = 1'b1; wr_data = b;
            @(negedge clk);
            wr_en = 1'b0;
            chk("R6", "empty after early write", data_empty, 1'b0);
            @(ev_bit);
        end
        brk_start = 1'b1; brk_len = 2'(code);
        @(negedge clk);
        brk_start = 1'b0;
        chk("R2", "busy after request", busy, 1'b1);
        chk("R2", "line before first tick", tx_out, 1'b1);
        last = put ? len + 13 : len + 3;
        for (int k = 1; k <= last; k++) begin
            @(ev_bit);
            if (k <= len)                   etx = 1'b0;
            else if (k == len + 1)          etx = 1'b1;
            else if (!put)                  etx = 1'b1;
            else if (k == len + 2)          etx = 1'b0;
            else if (k <= len + 10)         etx = b[k - len - 3];
            else                            etx = 1'b1;
            ebusy  = put ? (k <= len + 11) : (k <= len + 1);
            if (!put)                       eempty = 1'b1;
            else if (k >= len + 2)          eempty = 1'b1;
            else if (early || k >= 3)       eempty = 1'b0;
            else                            eempty = 1'b1;
            if (k <= len)
                chk("R3", "break bit", tx_out, etx);
            else if (k == len + 1)
                chk("R4", "delimiter", tx_out, etx);
            else if (put)
                chk("R5", "frame bit", tx_out, etx);
            else
                chk("R7", "no-byte idle line", tx_out, etx);
            if (put)
                chk("R10", "busy", busy, ebusy);
            else
                chk("R7", "busy", busy, ebusy);
            chk("R6", "data_empty", data_empty, eempty);
            if (put && !early && k == 2) begin
                wr_en = 1'b1; wr_data = b;
                @(negedge clk);
                wr_en = 1'b0;
                if (dbl) begin
                    wr_en = 1'b1; wr_data = ~b;
                    @(negedge clk);
                    wr_en = 1'b0;
                    chk("R9", "still full after second write", data_empty, 1'b0);
                end
            end
            if (late && k == len + 5) begin
                brk_start = 1'b1; brk_len = 2'd0;
                @(negedge clk);
                brk_start = 1'b0;
                chk("R8", "busy kept during frame", busy, 1'b1);
            end
            if (k == len) begin
                @(negedge clk);
                chk("R11", "line held between ticks", tx_out, 1'b0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset line", tx_out, 1'b1);
        chk("R1", "reset busy", busy, 1'b0);
        chk("R1", "reset empty", data_empty, 1'b1);
        for (int c = 0; c < 4; c++) begin
            run_frame(c, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
            run_frame(c, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0);
            run_frame(c, 1'b1, 1'b0, 8'hA3, 1'b1, 1'b0);
            run_frame(c, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
            run_frame(c, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b1);
            run_frame(c, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0);
        end
        @(ev_bit);
        chk("R1", "idle line at end", tx_out, 1'b1);
        chk("R1", "idle busy at end", busy, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1900000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule